// File: doc/BRIEF.md
# Center-Spread Triangle Frequency-Word Modulator

This block runs on a reference clock and produces a frequency-control word for a downstream synthesiser or fractional divider. While enabled, it moves that word along a symmetric triangle centred on a nominal value. The word climbs to the upper extreme, falls through the nominal value to the lower extreme, and then climbs back to the nominal value. The triangle repeats once per modulation period. The length of a period, counted in reference cycles, comes from a fixed divider chosen by a 2-bit range code. The depth of the swing comes from a 3-bit spread code.

A four-state machine drives the sweep. PH_IDLE holds the word at nominal while the block is disabled. PH_RISE covers the first quarter of the period, PH_FALL the middle half, and PH_RECOVER the last quarter. The transitions are:
- "start": PH_IDLE to PH_RISE, when enable is high.
- "crest": PH_RISE to PH_FALL, after N/4 cycles.
- "trough": PH_FALL to PH_RECOVER, after 3N/4 cycles.
- "wrap": PH_RECOVER to PH_RISE, at the end of the period.
- "halt": any state to PH_IDLE, when enable is low.

On start and on wrap, the block samples the range code, the spread code and the nominal word. It then computes a new per-cycle step. Settings therefore change only while the offset is zero, and the output never jumps.

Top module: `sscg_mod_ctrl`

## Requirements
- R1: A synchronous active-high rst makes out_word equal to nominal_in at the following clock edge, and the block comes out of reset idle.
- R2: While enable is low, each clock edge loads nominal_in into out_word, with no modulation. If enable is sampled high while the block is idle, the next output is nominal_in as sample 0 of a new period.
- R3: The period length N is set by range_sel: 2'b00 gives 120 cycles, 2'b01 gives 240, 2'b10 gives 480 and 2'b11 gives 720. The profile repeats every N cycles, and out_word equals the nominal value at every sample index that is a multiple of N.
- R4: With Q = N/4, the offset at sample j of a period is step·j for j ≤ Q, step·(2Q−j) for Q ≤ j ≤ 3Q, and step·(j−4Q) for j ≥ 3Q. out_word is nominal + floor(offset / 2^FRAC_W).
- R5: spread_code values 0 to 6 select a total spread of 1.0% to 4.0% in 0.5% increments, so k = spread_code + 2 half-percent units. The step is floor(nominal·k·2^FRAC_W / (100·N)), which makes the peak step·Q ≈ nominal·(k/2)/200.
- R6: spread_code 7 behaves exactly like spread_code 6.
- R7: The sweep is centre-spread. The upper excursion (max − nominal) and the lower excursion (nominal − min) differ by at most one LSB. The offset returns to exactly zero at every wrap.
- R8: range_sel, spread_code and nominal_in are sampled only on start and on wrap. A change in the middle of a period leaves the rest of that period unchanged, and it applies from the next period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Modulation enable; low holds the output at nominal |
| range_sel | input | 2 | Period-length code (120/240/480/720 cycles) |
| spread_code | input | 3 | Total spread, 1.0% to 4.0% in 0.5% increments |
| nominal_in | input | WORD_W | Nominal (centre) control word |
| out_word | output | WORD_W | Registered modulated control word |

## Verification
Two events can land in the same cycle: the wrap edge, where the block resamples its settings, and a change of those settings by the bench. To provoke this, the bench alters range_sel and spread_code in the last cycle of a period. It then checks that the very next sample belongs to a period built from the new values. In a second case, the bench changes the settings far from the boundary. There it checks that the old profile runs on to the end of the period before the new one takes over. A third case drops enable in the middle of a sweep, where halt competes with the running step accumulation. The output must snap to nominal on the next sample.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RISE    = 2'd1,
        PH_FALL    = 2'd2,
        PH_RECOVER = 2'd3
    } phase_t;

    localparam int unsigned DIV_MAX = 720;

    // Reference cycles per modulation period for each range code
    function automatic int unsigned period_len(input logic [1:0] sel);
        case (sel)
            2'b00:   return 120;
            2'b01:   return 240;
            2'b10:   return 480;
            default: return 720;
        endcase
    endfunction

endpackage

// File: rtl/sscg_phase_fsm.sv
module sscg_phase_fsm
    import sscg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       range_sel,
    output phase_t           phase,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lim,
    output logic             load
);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic [CNT_W-1:0] lim_in;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] three_q;

    assign lim_in  = CNT_W'(period_len(range_sel));
    assign quarter = lim_q >> 2;
    assign three_q = quarter + (quarter << 1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            lim_q   <= lim_in;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    // Next state and outputs
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q + 1'b1;
        lim_d   = lim_q;
        load    = 1'b0;
        if (!enable) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    load    = 1'b1;
                    phase_d = PH_RISE;
                    cnt_d   = '0;
                    lim_d   = lim_in;
                end
                PH_RISE: begin
                    if (cnt_q == quarter - 1'b1) phase_d = PH_FALL;
                end
                PH_FALL: begin
                    if (cnt_q == three_q - 1'b1) phase_d = PH_RECOVER;
                end
                PH_RECOVER: begin
                    if (cnt_q == lim_q - 1'b1) begin
                        load    = 1'b1;
                        phase_d = PH_RISE;
                        cnt_d   = '0;
                        lim_d   = lim_in;
                    end
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign cnt   = cnt_q;
    assign lim   = lim_q;

endmodule

// File: rtl/sscg_step_calc.sv
module sscg_step_calc
    import sscg_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int FRAC_W = 8,
    parameter int STEP_W = WORD_W + 4 + FRAC_W
) (
    input  logic [WORD_W-1:0] nominal_in,
    input  logic [2:0]        spread_code,
    input  logic [1:0]        range_sel,
    output logic [STEP_W-1:0] step
);

    logic [3:0]        k_half;
    logic [STEP_W-1:0] num;
    logic [STEP_W-1:0] den;

    // Half-percent units; code 7 saturates to the 4.0% setting
    assign k_half = (spread_code > 3'd6) ? 4'd8 : ({1'b0, spread_code} + 4'd2);
    assign num    = (STEP_W'(nominal_in) * STEP_W'(k_half)) << FRAC_W;
    assign den    = STEP_W'(100 * period_len(range_sel));
    assign step   = num / den;

endmodule

// File: rtl/sscg_offset_acc.sv
module sscg_offset_acc #(
    parameter int WORD_W = 24,
    parameter int FRAC_W = 8,
    parameter int STEP_W = WORD_W + 4 + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              load,
    input  logic              dir_up,
    input  logic [WORD_W-1:0] nominal_in,
    input  logic [STEP_W-1:0] step_in,
    output logic [WORD_W-1:0] out_word
);

    localparam int OFF_W = STEP_W + 2;

    logic signed [OFF_W-1:0] off_q, off_d;
    logic signed [OFF_W-1:0] step_x;
    logic signed [OFF_W-1:0] whole;
    logic [STEP_W-1:0]       step_q, step_d;
    logic [WORD_W-1:0]       nom_q, nom_d;
    logic [WORD_W-1:0]       out_q, out_d;

    assign step_x = signed'({2'b00, step_q});

    always_comb begin
        step_d = load ? step_in : step_q;
        if (!enable || load) begin
            off_d = '0;
            nom_d = nominal_in;
        end else begin
            off_d = dir_up ? (off_q + step_x) : (off_q - step_x);
            nom_d = nom_q;
        end
        whole = off_d >>> FRAC_W;
        out_d = nom_d + whole[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            step_q <= '0;
            nom_q  <= nominal_in;
            out_q  <= nominal_in;
        end else begin
            off_q  <= off_d;
            step_q <= step_d;
            nom_q  <= nom_d;
            out_q  <= out_d;
        end
    end

    assign out_word = out_q;

endmodule

// File: rtl/sscg_mod_ctrl.sv
module sscg_mod_ctrl
    import sscg_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        range_sel,
    input  logic [2:0]        spread_code,
    input  logic [WORD_W-1:0] nominal_in,
    output logic [WORD_W-1:0] out_word
);

    localparam int CNT_W  = $clog2(DIV_MAX);
    localparam int STEP_W = WORD_W + 4 + FRAC_W;

    phase_t            phase_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  lim_w;
    logic              load_w;
    logic [STEP_W-1:0] step_w;
    logic              dir_up_w;

    assign dir_up_w = (phase_w == PH_RISE) || (phase_w == PH_RECOVER);

    sscg_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .range_sel (range_sel),
        .phase     (phase_w),
        .cnt       (cnt_w),
        .lim       (lim_w),
        .load      (load_w)
    );

    sscg_step_calc #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_step (
        .nominal_in  (nominal_in),
        .spread_code (spread_code),
        .range_sel   (range_sel),
        .step        (step_w)
    );

    sscg_offset_acc #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .load       (load_w),
        .dir_up     (dir_up_w),
        .nominal_in (nominal_in),
        .step_in    (step_w),
        .out_word   (out_word)
    );

endmodule

// File: rtl/sscg_mod_ctrl_chk.sv
module sscg_mod_ctrl_chk
    import sscg_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic [WORD_W-1:0] nominal_in,
    input logic [WORD_W-1:0] out_word,
    input phase_t            phase,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  lim
);

    // R1
    reset_nominal_chk: assert property (@(posedge clk)
        rst |=> (out_word == $past(nominal_in)));

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (out_word == $past(nominal_in)) && (phase == PH_IDLE));

    // R3
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (cnt < lim));

    // R4
    crest_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && phase == PH_RISE && cnt == (lim >> 2) - 1'b1) |=> (phase == PH_FALL));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && phase == PH_RECOVER && cnt == lim - 1'b1)
        |=> (out_word == $past(nominal_in)) && (cnt == '0));

    // R8
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(lim));

endmodule

bind sscg_mod_ctrl sscg_mod_ctrl_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .nominal_in (nominal_in),
    .out_word   (out_word),
    .phase      (phase_w),
    .cnt        (cnt_w),
    .lim        (lim_w)
);

// File: tb/sscg_mod_ctrl_test.sv
`timescale 1ns/1ps
module sscg_mod_ctrl_test;

    localparam int WORD_W = 24;
    localparam int FRAC_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic [1:0]        range_sel = 2'b00;
    logic [2:0]        spread_code = 3'd0;
    logic [WORD_W-1:0] nominal_in = '0;
    logic [WORD_W-1:0] out_word;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sscg_mod_ctrl #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) uut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .range_sel   (range_sel),
        .spread_code (spread_code),
        .nominal_in  (nominal_in),
        .out_word    (out_word)
    );

    function automatic int div_of(input int rsel);
        case (rsel)
            0: return 120;
            1: return 240;
            2: return 480;
            default: return 720;
        endcase
    endfunction

    function automatic longint step_of(input longint nom, input int code, input int rsel);
        int k;
        k = ((code > 6) ? 6 : code) + 2;
        return (nom * k * (longint'(1) << FRAC_W)) / (100 * div_of(rsel));
    endfunction

    function automatic longint exp_out(input longint nom, input int code, input int rsel, input int j);
        int n, q;
        longint st, off;
        n  = div_of(rsel);
        q  = n / 4;
        st = step_of(nom, code, rsel);
        if (j <= q)          off = st * j;
        else if (j <= 3 * q) off = st * (2 * q - j);
        else                 off = st * (j - 4 * q);
        return nom + (off >>> FRAC_W);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // R1, R2: reset state and idle following
    task automatic t_reset();
        rst = 1'b1;
        nominal_in = 24'd500_000;
        repeat (3) @(negedge clk);
        check("R1 reset output", out_word, 500_000);
        rst = 1'b0;
        nominal_in = 24'd700_000;
        @(negedge clk);
        check("R2 idle follows nominal", out_word, 700_000);
        @(negedge clk);
        check("R2 idle holds nominal", out_word, 700_000);
    endtask

    // R3, R4, R5, R7 full profile over several periods
    task automatic t_profile(input string tag, input int rsel, input int code,
                             input longint nom, input int periods);
        int n, q, errs;
        longint mx, mn;
        n = div_of(rsel);
        q = n / 4;
        errs = 0;
        mx = nom;
        mn = nom;
        @(negedge clk);
        range_sel = 2'(rsel);
        spread_code = 3'(code);
        nominal_in = WORD_W'(nom);
        enable = 1'b1;
        for (int j = 0; j < periods * n; j++) begin
            @(negedge clk);
            if (longint'(out_word) > mx) mx = out_word;
            if (longint'(out_word) < mn) mn = out_word;
            if (longint'(out_word) != exp_out(nom, code, rsel, j % n)) begin
                if (errs == 0)
                    check({tag, " R4 profile sample"}, out_word, exp_out(nom, code, rsel, j % n));
                errs++;
            end
            if (j % n == 0) check({tag, " R3 nominal at period start"}, out_word, nom);
            if (j == q)
                check({tag, " R5 peak"}, longint'(out_word) - nom,
                      (step_of(nom, code, rsel) * q) >>> FRAC_W);
        end
        check({tag, " R4 all samples match"}, errs, 0);
        check({tag, " R7 symmetric extremes"},
              ((nom - mn) - (mx - nom) <= 1 && (nom - mn) - (mx - nom) >= 0) ? 1 : 0, 1);
        go_idle();
    endtask

    // R6: code 7 equals code 6
    task automatic t_clamp();
        int errs;
        errs = 0;
        @(negedge clk);
        range_sel = 2'b00;
        spread_code = 3'd7;
        nominal_in = 24'd2_000_000;
        enable = 1'b1;
        for (int j = 0; j < 120; j++) begin
            @(negedge clk);
            if (longint'(out_word) != exp_out(2_000_000, 6, 0, j)) errs++;
            if (j == 30) check("R6 code 7 peak equals code 6 peak", out_word, exp_out(2_000_000, 6, 0, 30));
        end
        check("R6 code 7 profile equals code 6", errs, 0);
        go_idle();
    endtask

    // R8: mid-period change, and change coinciding with wrap
    task automatic t_midchange();
        int errs;
        errs = 0;
        @(negedge clk);
        range_sel = 2'b01;
        spread_code = 3'd0;
        nominal_in = 24'd1_500_000;
        enable = 1'b1;
        for (int j = 0; j < 240; j++) begin
            @(negedge clk);
            if (longint'(out_word) != exp_out(1_500_000, 0, 1, j)) errs++;
            if (j == 100) check("R8 old profile after mid change", out_word, exp_out(1_500_000, 0, 1, 100));
            if (j == 10) begin
                range_sel = 2'b10;
                spread_code = 3'd4;
                nominal_in = 24'd3_000_000;
            end
        end
        check("R8 old period unaffected", errs, 0);
        errs = 0;
        for (int j = 0; j < 480; j++) begin
            @(negedge clk);
            if (longint'(out_word) != exp_out(3_000_000, 4, 2, j)) errs++;
            if (j == 120) check("R8 new peak applied", out_word, exp_out(3_000_000, 4, 2, 120));
            if (j == 479) begin
                range_sel = 2'b00;
                spread_code = 3'd1;
            end
        end
        check("R8 new period follows new settings", errs, 0);
        errs = 0;
        for (int j = 0; j < 120; j++) begin
            @(negedge clk);
            if (longint'(out_word) != exp_out(3_000_000, 1, 0, j)) errs++;
        end
        check("R8 change at wrap cycle takes effect", errs, 0);
        go_idle();
    endtask

    // R2: halt mid sweep and restart
    task automatic t_disable();
        @(negedge clk);
        range_sel = 2'b00;
        spread_code = 3'd3;
        nominal_in = 24'd1_000_000;
        enable = 1'b1;
        for (int j = 0; j < 50; j++) @(negedge clk);
        check("R2 mid sweep sample", out_word, exp_out(1_000_000, 3, 0, 49));
        enable = 1'b0;
        @(negedge clk);
        check("R2 halt snaps to nominal", out_word, 1_000_000);
        nominal_in = 24'd1_200_000;
        repeat (3) @(negedge clk);
        check("R2 disabled no modulation", out_word, 1_200_000);
        enable = 1'b1;
        @(negedge clk);
        check("R2 restart sample 0", out_word, 1_200_000);
        for (int j = 1; j <= 20; j++) @(negedge clk);
        check("R2 restart from period start", out_word, exp_out(1_200_000, 3, 0, 20));
        go_idle();
    endtask

    initial begin
        #750_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_profile("rs00", 0, 2, 1_000_000, 2);
        t_profile("rs11", 3, 6, 4_000_000, 1);
        t_profile("rs01", 1, 0, 12_000_000, 1);
        t_clamp();
        t_midchange();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule